// File: doc/BRIEF.md
# Address-Sequence Unlock Detector

This block monitors the address of every read cycle on a host bus and looks for a hidden three-read key: two reads of a "step" location and one read of a "final" location, all inside one key page. Once that key has been seen, the detector is open. While it is open, a read inside a capture window loads a 4-bit bank number from the low address bits. A read of a commit location then emits a one-cycle change pulse and locks the detector again. Write cycles never affect it.

Two address profiles are built in. The `profile_sel` input chooses between them, so one instance can serve either host family. The block only produces the bank number, the pulse and the lock state; a downstream consumer acts on them.

Top module: `addr_unlock_detector`

## Requirements
- R1: While `rst_n` is low and afterwards until the first qualifying read, `lock_state` is 0, `bank_q` is 0 and `change_pulse` is 0.
- R2: A cycle with `bus_valid` low, or with `bus_read` low (a write), leaves `lock_state` and `bank_q` unchanged and gives no pulse.
- R3: A read in the key page with low byte 0xCA moves `lock_state` from 1 to 2. From 0, 2 or 3 it moves to 1.
- R4: A read in the key page with low byte 0xFE moves `lock_state` from 2 to 3. From 0, 1 or 3 it moves to 0.
- R5: A read in the key page with any other low byte clears `lock_state` to 0, except in state 3, where the state stays 3.
- R6: A read outside the key page while `lock_state` is below 3 leaves the state unchanged.
- R7: While `lock_state` is 3, a read whose address bits 15:4 equal the capture prefix loads `bank_q` from address bits 3:0. The prefix is 0xF81 with `profile_sel`=1 and 0xCFD with `profile_sel`=0. In any other state such a read leaves `bank_q` unchanged.
- R8: While `lock_state` is 3, a read of the commit address asserts `change_pulse` and sets `lock_state` to 0 on the same clock edge. The commit address is exactly 0xF851 with `profile_sel`=1 and any of 0xCFE0 to 0xCFEF with `profile_sel`=0.
- R9: The key page is the address high byte. It is 0xFA with `profile_sel`=1 and 0xCA with `profile_sel`=0. Reads in the other profile's page count as outside the key page.
- R10: `change_pulse` is high for exactly one cycle per commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_read | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 16 | Address of the bus cycle |
| profile_sel | input | 1 | 0 = profile with key page 0xCA, 1 = profile with key page 0xFA |
| bank_q | output | 4 | Captured bank number |
| change_pulse | output | 1 | One-cycle pulse on commit |
| lock_state | output | 2 | Detector state, 3 = open |

## Verification
The hardest conditions to reach are the ones that only exist after a full unlock: a step read that knocks an open detector back to state 1, an unrelated key-page read that leaves it open, and a capture or commit read issued under the wrong profile. Directed sequences first unlock the detector and then deliver each of these reads. A long biased random phase follows. Most of its addresses come from the key, capture and commit values of both profiles, with random profile switches and interleaved writes. A behavioural model of the state, the bank and the pulse is compared against the outputs on every clock.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ONE  = 2'd1,
      ST_TWO  = 2'd2,
      ST_OPEN = 2'd3
   } lock_st_t;

   typedef struct packed {
      logic key_hit;    // address is inside the selected key page
      logic key_step;   // key page, step low byte
      logic key_final;  // key page, final low byte
      logic grab;       // capture window match
      logic commit;     // commit address match
   } addr_class_t;

endpackage

// File: rtl/seq_addr_decode.sv
module seq_addr_decode
   import unlock_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8,
   parameter int BANK_W = 4,
   localparam int LO_W  = ADDR_W - PAGE_W,
   localparam int PFX_W = ADDR_W - BANK_W,
   parameter logic [PAGE_W-1:0] P0_KEY_PAGE   = 'hCA,
   parameter logic [PAGE_W-1:0] P1_KEY_PAGE   = 'hFA,
   parameter logic [LO_W-1:0]   STEP_LO       = 'hCA,
   parameter logic [LO_W-1:0]   FINAL_LO      = 'hFE,
   parameter logic [PFX_W-1:0]  P0_GRAB_PFX   = 'hCFD,
   parameter logic [PFX_W-1:0]  P1_GRAB_PFX   = 'hF81,
   parameter logic [ADDR_W-1:0] P0_COMMIT     = 'hCFE0,
   parameter logic [ADDR_W-1:0] P0_COMMIT_MSK = 'hFFF0,
   parameter logic [ADDR_W-1:0] P1_COMMIT     = 'hF851,
   parameter logic [ADDR_W-1:0] P1_COMMIT_MSK = 'hFFFF
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              profile,
   output addr_class_t       cls,
   output logic [BANK_W-1:0] bank_field
);

   logic [1:0] page_m;
   logic [1:0] grab_m;
   logic [1:0] commit_m;

   for (genvar g = 0; g < 2; g++) begin : g_prof
      localparam logic [PAGE_W-1:0] KP  = (g == 0) ? P0_KEY_PAGE   : P1_KEY_PAGE;
      localparam logic [PFX_W-1:0]  GP  = (g == 0) ? P0_GRAB_PFX   : P1_GRAB_PFX;
      localparam logic [ADDR_W-1:0] CA  = (g == 0) ? P0_COMMIT     : P1_COMMIT;
      localparam logic [ADDR_W-1:0] CM  = (g == 0) ? P0_COMMIT_MSK : P1_COMMIT_MSK;
      assign page_m[g]   = (addr[ADDR_W-1 -: PAGE_W] == KP);
      assign grab_m[g]   = (addr[ADDR_W-1 -: PFX_W] == GP);
      assign commit_m[g] = ((addr & CM) == (CA & CM));
   end

   always_comb begin
      cls.key_hit   = page_m[profile];
      cls.key_step  = page_m[profile] && (addr[LO_W-1:0] == STEP_LO);
      cls.key_final = page_m[profile] && (addr[LO_W-1:0] == FINAL_LO);
      cls.grab      = !page_m[profile] && grab_m[profile];
      cls.commit    = !page_m[profile] && commit_m[profile];
   end

   assign bank_field = addr[BANK_W-1:0];

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
   import unlock_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_stb,
   input  addr_class_t cls,
   output lock_st_t    state,
   output logic        change_pulse
);

   lock_st_t nxt;
   logic     fire;

   always_comb begin
      nxt  = state;
      fire = 1'b0;
      if (rd_stb) begin
         if (cls.key_step) begin
            nxt = (state == ST_ONE) ? ST_TWO : ST_ONE;
         end else if (cls.key_final) begin
            nxt = (state == ST_TWO) ? ST_OPEN : ST_IDLE;
         end else if (cls.key_hit) begin
            if (state != ST_OPEN) nxt = ST_IDLE;
         end else if (state == ST_OPEN && cls.commit) begin
            nxt  = ST_IDLE;
            fire = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         change_pulse <= 1'b0;
      end else begin
         state        <= nxt;
         change_pulse <= fire;
      end
   end

   AST_OPEN_FROM_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPEN && $past(state) != ST_OPEN) |-> $past(state) == ST_TWO); // R4
   AST_STEP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cls.key_step) |=> (state == ST_ONE || state == ST_TWO)); // R3
   AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !cls.key_hit && state != ST_OPEN) |=> $stable(state)); // R6
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      change_pulse |=> !change_pulse); // R10
   AST_PULSE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      change_pulse |-> state == ST_IDLE); // R8
   AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cls.key_hit && !cls.key_step && !cls.key_final && state == ST_OPEN)
      |=> state == ST_OPEN); // R5

endmodule

// File: rtl/bank_hold.sv
module bank_hold #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BANK_W-1:0] din,
   output logic [BANK_W-1:0] bank_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bank_q <= '0;
      else if (load) bank_q <= din;
   end

endmodule

// File: rtl/addr_unlock_detector.sv
module addr_unlock_detector
   import unlock_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8,
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_read,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              profile_sel,
   output logic [BANK_W-1:0] bank_q,
   output logic              change_pulse,
   output logic [1:0]        lock_state
);

   localparam int LO_W = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || LO_W < 8) begin : g_bad_split
      $error("addr_unlock_detector: low part of the address must hold at least 8 bits");
   end
   if (BANK_W < 1 || BANK_W >= LO_W) begin : g_bad_bank
      $error("addr_unlock_detector: BANK_W must be between 1 and the low-part width");
   end

   addr_class_t          cls;
   logic [BANK_W-1:0]    bank_field;
   logic                 rd_stb;
   lock_st_t             state;

   assign rd_stb = bus_valid && bus_read;

   seq_addr_decode #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .BANK_W (BANK_W)
   ) u_decode (
      .addr       (bus_addr),
      .profile    (profile_sel),
      .cls        (cls),
      .bank_field (bank_field)
   );

   lock_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_stb       (rd_stb),
      .cls          (cls),
      .state        (state),
      .change_pulse (change_pulse)
   );

   bank_hold #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (rd_stb && state == ST_OPEN && cls.grab),
      .din    (bank_field),
      .bank_q (bank_q)
   );

   assign lock_state = state;

   AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_valid && bus_read)) |=> ($stable(lock_state) && $stable(bank_q) && !change_pulse)); // R2
   AST_BANK_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank_q) |-> $past(lock_state) == 2'd3); // R7
   AST_RESET_VALUES: assert property (@(posedge clk)
      !rst_n |-> (lock_state == 2'd0 && bank_q == '0 && !change_pulse)); // R1

endmodule

// File: tb/addr_unlock_detector_bench.sv
`timescale 1ns/1ps
module addr_unlock_detector_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_read = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        profile_sel = 1'b1;
   logic [3:0]  bank_q;
   logic        change_pulse;
   logic [1:0]  lock_state;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   addr_unlock_detector u_addr_unlock_detector (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_valid    (bus_valid),
      .bus_read     (bus_read),
      .bus_addr     (bus_addr),
      .profile_sel  (profile_sel),
      .bank_q       (bank_q),
      .change_pulse (change_pulse),
      .lock_state   (lock_state)
   );

   // behavioural reference model
   int    m_st;
   int    m_bank;
   bit    m_chg;
   string m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_bank = 0; m_chg = 0; m_req = "R1";
      end else begin
         m_chg = 0;
         m_req = "R2";
         if (bus_valid && bus_read) begin
            if (bus_addr[15:8] == (profile_sel ? 8'hFA : 8'hCA)) begin
               if (bus_addr[7:0] == 8'hCA) begin
                  m_st = (m_st == 1) ? 2 : 1; m_req = "R3";
               end else if (bus_addr[7:0] == 8'hFE) begin
                  m_st = (m_st == 2) ? 3 : 0; m_req = "R4";
               end else begin
                  if (m_st != 3) m_st = 0;
                  m_req = "R5";
               end
            end else if (m_st == 3) begin
               m_req = "R7";
               if (bus_addr[15:4] == (profile_sel ? 12'hF81 : 12'hCFD))
                  m_bank = bus_addr[3:0];
               if (profile_sel ? (bus_addr == 16'hF851) : (bus_addr[15:4] == 12'hCFE)) begin
                  m_chg = 1; m_st = 0; m_req = "R8";
               end
            end else begin
               m_req = "R6";
            end
         end
      end
   end

   always @(negedge clk) begin
      checks++;
      if (lock_state != m_st[1:0] || bank_q != m_bank[3:0] || change_pulse != m_chg) begin
         fails++;
         $display("FAIL %s model: actual st=%0d bank=%0h chg=%0b expected st=%0d bank=%0h chg=%0b",
                  m_req, lock_state, bank_q, change_pulse, m_st, m_bank, m_chg);
      end
   end

   task automatic expect_v(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic op(bit v, bit r, logic [15:0] a);
      bus_valid = v; bus_read = r; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic rd(logic [15:0] a);
      op(1'b1, 1'b1, a);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_v("R1 state", lock_state, 0);
      expect_v("R1 bank", bank_q, 0);
      expect_v("R1 pulse", change_pulse, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // profile 1, key page 0xFA
      profile_sel = 1'b1;
      rd(16'hFACA); expect_v("R3 0->1", lock_state, 1);
      rd(16'hFACA); expect_v("R3 1->2", lock_state, 2);
      rd(16'hFAFE); expect_v("R4 2->3", lock_state, 3);
      rd(16'hFA00); expect_v("R5 open stays", lock_state, 3);
      rd(16'hFACA); expect_v("R3 3->1", lock_state, 1);
      rd(16'hFACA); rd(16'hFAFE); expect_v("R4 reopen", lock_state, 3);
      op(1'b1, 1'b0, 16'hF815); expect_v("R2 write bank", bank_q, 0);
      expect_v("R2 write state", lock_state, 3);
      op(1'b0, 1'b1, 16'hFACA); expect_v("R2 idle state", lock_state, 3);
      rd(16'hF817); expect_v("R7 capture", bank_q, 7);
      rd(16'h1234); expect_v("R7 unrelated", lock_state, 3);
      rd(16'hF851); expect_v("R8 pulse", change_pulse, 1);
      expect_v("R8 relock", lock_state, 0);
      op(1'b0, 1'b0, 16'h0000); expect_v("R10 pulse drop", change_pulse, 0);
      rd(16'hF81A); expect_v("R7 locked capture", bank_q, 7);
      rd(16'hFACA); rd(16'h2000); expect_v("R6 outside hold", lock_state, 1);
      rd(16'hFACA); rd(16'hFA10); expect_v("R5 clear", lock_state, 0);
      rd(16'hFAFE); expect_v("R4 idle final", lock_state, 0);
      rd(16'hFACA); rd(16'hFACA); rd(16'hFACA); expect_v("R3 2->1", lock_state, 1);

      // profile 0, key page 0xCA
      profile_sel = 1'b0;
      rd(16'hFAFE); expect_v("R9 other page", lock_state, 1);
      rd(16'hFACA); expect_v("R9 foreign step", lock_state, 1);
      rd(16'hCACA); rd(16'hCAFE); expect_v("R9 unlock p0", lock_state, 3);
      rd(16'hCFD9); expect_v("R7 capture p0", bank_q, 9);
      rd(16'hF851); expect_v("R8 wrong commit", lock_state, 3);
      expect_v("R8 no pulse", change_pulse, 0);
      rd(16'hCFE4); expect_v("R8 commit p0", change_pulse, 1);
      expect_v("R8 relock p0", lock_state, 0);
      rd(16'hCFE4); expect_v("R10 no repeat", change_pulse, 0);

      // biased random phase
      for (int i = 0; i < 4000; i++) begin
         logic [15:0] a;
         int k;
         k = $urandom_range(0, 11);
         case (k)
            0, 1, 2: a = {($urandom_range(0,1) ? 8'hFA : 8'hCA), 8'hCA};
            3, 4:    a = {($urandom_range(0,1) ? 8'hFA : 8'hCA), 8'hFE};
            5:       a = {($urandom_range(0,1) ? 8'hFA : 8'hCA), 8'($urandom)};
            6:       a = {12'hF81, 4'($urandom)};
            7:       a = {12'hCFD, 4'($urandom)};
            8:       a = {12'hCFE, 4'($urandom)};
            9:       a = 16'hF851;
            default: a = 16'($urandom);
         endcase
         if ($urandom_range(0, 60) == 0) profile_sel = ~profile_sel;
         op($urandom_range(0, 9) != 0, $urandom_range(0, 7) != 0, a);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule